// File: doc/BRIEF.md
# ADC Sampling Sequencer

This block is the host-side controller for a self-timed 8-bit serial converter with three control wires: a start strobe, a serial clock and a serial data line from the converter. On a start request it raises the strobe for a fixed width, drops it to launch the conversion, and waits out the worst-case conversion time with the serial clock parked low. It then issues eight serial clocks and assembles the returned bits, MSB first, into a parallel byte. The byte is delivered with a one-cycle valid pulse.

The controller also drives the converter's active-low power pin. Wake-up timing depends on the reference in use: a short settle time for an external reference, a long one for an internal reference that may have fully discharged. An optional auto-sleep mode powers the converter down after every byte. If the host forces sleep in the middle of a conversion, the controller runs the flush sequence once power returns. That sequence is: wake delay, a full conversion wait, and eight discarded clocks. All timing constants are parameters counted in system-clock cycles.

Top module: `adcseq_ctrl`

## Requirements
- R1: While `rst` is high, `adc_cnv`, `adc_sclk` and `sample_valid` are 0 and `adc_pwr_n` is 0 (converter held powered down).
- R2: Each strobe pulse stays high for exactly STRB_CYC cycles and never reaches STRB_MAX_CYC cycles. The only exception is a pulse cut short by `sleep_req`.
- R3: `adc_sclk` never rises while `adc_cnv` is high. After the strobe falls, it stays low until the eighth serial clock has finished.
- R4: After the strobe falls, `adc_sclk` stays low for CONV_CYC cycles before the read begins. The first rising edge comes CONV_CYC + SCLK_HALF cycles after the fall.
- R5: `adc_sclk` idles low. Each high phase and each low phase lasts SCLK_HALF cycles, and every read has exactly eight rising edges.
- R6: The bit on `adc_dout` is sampled at each rising edge of `adc_sclk`. The first bit sampled becomes bit 7 of `sample_byte`. `sample_byte` is presented together with a `sample_valid` pulse lasting exactly one cycle.
- R7: A `start_req` pulse that arrives while a conversion is under way is remembered. Its strobe begins only after the eighth clock of the current read.
- R8: When power is released, the strobe rises WAKE_EXT_CYC+1 cycles later if `ref_internal`=0, and WAKE_INT_CYC+1 cycles later if `ref_internal`=1 (wake delay plus one idle cycle).
- R9: With `auto_sleep_en`=1, `adc_pwr_n` goes low after each byte is delivered. It stays low until the next `start_req`.
- R10: Raising `sleep_req` during strobe, conversion or read stops the sequence and drives `adc_pwr_n` low. On release, the controller waits the wake delay, then CONV_CYC cycles, then issues eight clocks. These clocks produce no `sample_valid` and no strobe; the first of them rises wake+CONV_CYC+SCLK_HALF cycles after power returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request for a conversion |
| sleep_req | input | 1 | Level: hold the converter powered down |
| auto_sleep_en | input | 1 | Power down after every delivered byte |
| ref_internal | input | 1 | 1 = internal reference (long wake), 0 = external |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cnv | output | 1 | Start strobe to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_pwr_n | output | 1 | Converter power enable, low = powered down |
| busy | output | 1 | Waking, strobing, converting or reading |
| sample_valid | output | 1 | One-cycle pulse marking a new byte |
| sample_byte | output | NBITS | Last captured conversion result |

## Verification
On every cycle, the assertions check four things: the serial clock stays low while the strobe is high and during the conversion wait; the strobe width falls inside its window; each clock phase is stable; and the bit counter stays bounded. They also check that the valid pulse never lasts two cycles and that strobe and clock stay quiet while power is off. Only the bench scenarios can show the remaining behaviour. That covers the values of the assembled bytes and the exact wake and conversion gaps for each reference setting. It also covers holding a request across a busy read, entering and leaving auto-sleep, and the silent flush sequence after a forced mid-conversion sleep.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAKE,
        ST_IDLE,
        ST_STRB,
        ST_CONV,
        ST_READ
    } seq_state_e;

    typedef struct packed {
        logic cnv;
        logic pwr_n;
        logic busy;
    } pin_drive_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic pin_drive_t decode_pins(input seq_state_e s);
        pin_drive_t p;
        p.cnv   = (s == ST_STRB);
        p.pwr_n = (s != ST_OFF);
        p.busy  = (s == ST_WAKE) || (s == ST_STRB) || (s == ST_CONV) || (s == ST_READ);
        return p;
    endfunction

endpackage

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/adcseq_shift.sv
module adcseq_shift #(
    parameter int NBITS    = 8,
    parameter int HALF_CYC = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             abort,
    input  logic             sdi,
    output logic             sclk,
    output logic [NBITS-1:0] data,
    output logic             done
);
    localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int BW = $clog2(NBITS + 1);

    logic             active_q;
    logic             sclk_q;
    logic [PW-1:0]    ph_q;
    logic [BW-1:0]    bits_q;
    logic [NBITS-1:0] sr_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            ph_q     <= '0;
            bits_q   <= '0;
            sr_q     <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                active_q <= 1'b0;
                sclk_q   <= 1'b0;
            end else if (go) begin
                active_q <= 1'b1;
                sclk_q   <= 1'b0;
                ph_q     <= '0;
                bits_q   <= '0;
            end else if (active_q) begin
                if (ph_q == PW'(HALF_CYC - 1)) begin
                    ph_q <= '0;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        sr_q   <= {sr_q[NBITS-2:0], sdi};
                    end else begin
                        sclk_q <= 1'b0;
                        bits_q <= bits_q + 1'b1;
                        if (bits_q == BW'(NBITS - 1)) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                        end
                    end
                end else begin
                    ph_q <= ph_q + 1'b1;
                end
            end
        end
    end

    assign sclk = sclk_q;
    assign data = sr_q;
    assign done = done_q;

    p_sclk_rests_low_r5: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> !sclk_q);

    p_bit_count_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        bits_q <= BW'(NBITS));

    generate
        if (HALF_CYC > 1) begin : g_phase_chk
            p_phase_hold_r5: assert property (@(posedge clk) disable iff (rst)
                (!abort && ($rose(sclk_q) || $fell(sclk_q))) |=> $stable(sclk_q));
        end
    endgenerate

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int NBITS        = 8,
    parameter int STRB_CYC     = 200,
    parameter int STRB_MAX_CYC = 20000,
    parameter int CONV_CYC     = 7000,
    parameter int SCLK_HALF    = 50,
    parameter int WAKE_EXT_CYC = 4000,
    parameter int WAKE_INT_CYC = 2400000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             sleep_req,
    input  logic             auto_sleep_en,
    input  logic             ref_internal,
    input  logic             adc_dout,
    output logic             adc_cnv,
    output logic             adc_sclk,
    output logic             adc_pwr_n,
    output logic             busy,
    output logic             sample_valid,
    output logic [NBITS-1:0] sample_byte
);
    localparam int MAXC = imax(imax(STRB_CYC, CONV_CYC), imax(WAKE_EXT_CYC, WAKE_INT_CYC));
    localparam int TW   = $clog2(MAXC + 1);
    localparam int SW   = $clog2(STRB_MAX_CYC + 2);

    seq_state_e       state_q, state_d;
    logic             pend_q, recover_q;
    logic             t_load, t_zero;
    logic [TW-1:0]    t_val;
    logic             sh_go, sh_abort, sh_done;
    logic [NBITS-1:0] sh_data;
    logic             valid_q;
    logic [NBITS-1:0] byte_q;
    pin_drive_t       pins;
    logic [TW-1:0]    wake_val;

    assign wake_val = ref_internal ? TW'(WAKE_INT_CYC - 1) : TW'(WAKE_EXT_CYC - 1);

    always_comb begin
        state_d  = state_q;
        t_load   = 1'b0;
        t_val    = '0;
        sh_go    = 1'b0;
        sh_abort = 1'b0;
        case (state_q)
            ST_OFF: begin
                if (!sleep_req && (recover_q || pend_q || start_req || !auto_sleep_en)) begin
                    state_d = ST_WAKE;
                    t_load  = 1'b1;
                    t_val   = wake_val;
                end
            end
            ST_WAKE: begin
                if (t_zero) begin
                    if (recover_q) begin
                        state_d = ST_CONV;
                        t_load  = 1'b1;
                        t_val   = TW'(CONV_CYC - 1);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_IDLE: begin
                if (start_req || pend_q) begin
                    state_d = ST_STRB;
                    t_load  = 1'b1;
                    t_val   = TW'(STRB_CYC - 1);
                end
            end
            ST_STRB: begin
                if (t_zero) begin
                    state_d = ST_CONV;
                    t_load  = 1'b1;
                    t_val   = TW'(CONV_CYC - 1);
                end
            end
            ST_CONV: begin
                if (t_zero) begin
                    state_d = ST_READ;
                    sh_go   = 1'b1;
                end
            end
            ST_READ: begin
                if (sh_done)
                    state_d = auto_sleep_en ? ST_OFF : ST_IDLE;
            end
            default: state_d = ST_OFF;
        endcase
        if (sleep_req && state_q != ST_OFF) begin
            state_d  = ST_OFF;
            t_load   = 1'b0;
            sh_go    = 1'b0;
            sh_abort = (state_q == ST_READ);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_OFF;
            pend_q    <= 1'b0;
            recover_q <= 1'b0;
            valid_q   <= 1'b0;
            byte_q    <= '0;
        end else begin
            state_q <= state_d;
            valid_q <= 1'b0;

            if (state_q == ST_IDLE && state_d == ST_STRB)
                pend_q <= 1'b0;
            else if (start_req)
                pend_q <= 1'b1;

            if (sleep_req && (state_q == ST_STRB || state_q == ST_CONV || state_q == ST_READ))
                recover_q <= 1'b1;
            else if (state_q == ST_READ && sh_done)
                recover_q <= 1'b0;

            if (state_q == ST_READ && sh_done && !recover_q && !sleep_req) begin
                valid_q <= 1'b1;
                byte_q  <= sh_data;
            end
        end
    end

    adcseq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    adcseq_shift #(.NBITS(NBITS), .HALF_CYC(SCLK_HALF)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .go    (sh_go),
        .abort (sh_abort),
        .sdi   (adc_dout),
        .sclk  (adc_sclk),
        .data  (sh_data),
        .done  (sh_done)
    );

    assign pins         = decode_pins(state_q);
    assign adc_cnv      = pins.cnv;
    assign adc_pwr_n    = pins.pwr_n;
    assign busy         = pins.busy;
    assign sample_valid = valid_q;
    assign sample_byte  = byte_q;

    // strobe width monitor for the window checks
    logic [SW-1:0] strb_cnt_q;
    always_ff @(posedge clk) begin
        if (rst)
            strb_cnt_q <= '0;
        else if (adc_cnv)
            strb_cnt_q <= strb_cnt_q + 1'b1;
        else
            strb_cnt_q <= '0;
    end

    p_strobe_min_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(adc_cnv) && adc_pwr_n) |-> (strb_cnt_q >= SW'(STRB_CYC)));

    p_strobe_cap_r2: assert property (@(posedge clk) disable iff (rst)
        adc_cnv |-> (strb_cnt_q < SW'(STRB_MAX_CYC)));

    p_no_clock_in_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        adc_cnv |-> !adc_sclk);

    p_quiet_conversion_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV) |-> !adc_sclk);

    p_valid_single_r6: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    p_off_is_silent_r10: assert property (@(posedge clk) disable iff (rst)
        !adc_pwr_n |-> (!adc_cnv && !adc_sclk));

endmodule

// File: tb/sim_adcseq_ctrl.sv
`timescale 1ns/1ps
module sim_adcseq_ctrl;
    localparam int STRB = 4;
    localparam int SMAX = 20;
    localparam int CONV = 30;
    localparam int HALF = 2;
    localparam int WEXT = 10;
    localparam int WINT = 50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0, sleep_req = 1'b0, auto_sleep_en = 1'b0, ref_internal = 1'b0;
    logic adc_dout;
    logic adc_cnv, adc_sclk, adc_pwr_n, busy, sample_valid;
    logic [7:0] sample_byte;

    always #2.5 clk = ~clk;

    adcseq_ctrl #(
        .NBITS(8), .STRB_CYC(STRB), .STRB_MAX_CYC(SMAX), .CONV_CYC(CONV),
        .SCLK_HALF(HALF), .WAKE_EXT_CYC(WEXT), .WAKE_INT_CYC(WINT)
    ) u0 (
        .clk(clk), .rst(rst), .start_req(start_req), .sleep_req(sleep_req),
        .auto_sleep_en(auto_sleep_en), .ref_internal(ref_internal),
        .adc_dout(adc_dout), .adc_cnv(adc_cnv), .adc_sclk(adc_sclk),
        .adc_pwr_n(adc_pwr_n), .busy(busy), .sample_valid(sample_valid),
        .sample_byte(sample_byte)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [7:0] adc_val = 8'h00, adc_sr = 8'h00;
    assign adc_dout = adc_sr[7];

    // converter model and port monitors, sampled on the falling clock edge
    logic p_cnv = 0, p_sclk = 0, p_pwr = 0, p_valid = 0;
    int cnv_w = 0, last_cnv_w = 0, gap = 0, last_gap = 0, rises = 0, rises_at_cnv = 0;
    int n_cnv = 0, n_valid = 0, valid_long = 0, wk = 0, last_wk = 0, rg = 0, last_rg = 0;
    bit gap_on = 0, wk_on = 0, rg_on = 0;
    logic [7:0] last_byte = 8'h00;

    always @(negedge clk) begin
        cyc++;
        if (!adc_pwr_n) adc_sr = 8'h00;
        else if (p_cnv && !adc_cnv) adc_sr = adc_val;
        else if (p_sclk && !adc_sclk) adc_sr = {adc_sr[6:0], 1'b0};

        if (adc_pwr_n && !p_pwr) begin wk = 0; wk_on = 1; rg = 0; rg_on = 1; rises = 0; end
        if (wk_on) begin
            if (adc_cnv) begin last_wk = wk; wk_on = 0; end else wk++;
        end
        if (rg_on) begin
            if (adc_sclk) begin last_rg = rg; rg_on = 0; end
            else if (adc_cnv) rg_on = 0;
            else rg++;
        end
        if (adc_cnv && !p_cnv) begin n_cnv++; rises_at_cnv = rises; rises = 0; end
        if (adc_cnv) cnv_w++;
        if (!adc_cnv && p_cnv) begin last_cnv_w = cnv_w; cnv_w = 0; gap = 0; gap_on = 1; end
        if (gap_on) begin
            if (adc_sclk) begin last_gap = gap; gap_on = 0; end else gap++;
        end
        if (adc_sclk && !p_sclk) rises++;
        if (sample_valid) begin n_valid++; last_byte = sample_byte; end
        if (sample_valid && p_valid) valid_long++;
        p_cnv = adc_cnv; p_sclk = adc_sclk; p_pwr = adc_pwr_n; p_valid = sample_valid;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
    endtask

    task automatic wait_valid();
        int base = n_valid;
        for (int i = 0; i < 1000 && n_valid == base; i++) @(negedge clk);
        check(n_valid > base, "R6 valid arrives", n_valid, base + 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        wait_cycles(5);
        check(adc_cnv == 1'b0, "R1 cnv in reset", adc_cnv, 0);
        check(adc_sclk == 1'b0, "R1 sclk in reset", adc_sclk, 0);
        check(sample_valid == 1'b0, "R1 valid in reset", sample_valid, 0);
        check(adc_pwr_n == 1'b0, "R1 pwr_n in reset", adc_pwr_n, 0);
        rst = 1'b0;
        wait_cycles(WEXT + 5);
    endtask

    task automatic t_single(input logic [7:0] v);
        int c0 = n_cnv;
        adc_val = v;
        pulse_start();
        wait_valid();
        wait_cycles(2);
        check(last_byte == v, "R6 byte MSB first", last_byte, v);
        check(last_cnv_w == STRB, "R2 strobe width", last_cnv_w, STRB);
        check(last_gap == CONV + HALF, "R4 conversion gap", last_gap, CONV + HALF);
        check(rises == 8, "R5 eight clocks", rises, 8);
        check(n_cnv == c0 + 1, "R3 one strobe per sample", n_cnv, c0 + 1);
        check(valid_long == 0, "R6 valid one cycle", valid_long, 0);
    endtask

    task automatic t_held();
        int v0 = n_valid;
        int c0 = n_cnv;
        adc_val = 8'h3C;
        pulse_start();
        wait_cycles(10);
        pulse_start();
        wait_valid();
        wait_valid();
        wait_cycles(2);
        check(n_valid == v0 + 2, "R7 held request served", n_valid, v0 + 2);
        check(n_cnv == c0 + 2, "R7 two strobes", n_cnv, c0 + 2);
        check(rises_at_cnv == 8, "R7 second strobe after eighth clock", rises_at_cnv, 8);
        check(last_byte == 8'h3C, "R7 second byte", last_byte, 8'h3C);
    endtask

    task automatic t_auto(input bit use_int);
        int w = use_int ? WINT : WEXT;
        auto_sleep_en = 1'b1;
        ref_internal = use_int;
        t_single(8'h96);
        check(adc_pwr_n == 1'b0, "R9 sleep after byte", adc_pwr_n, 0);
        wait_cycles(20);
        check(adc_pwr_n == 1'b0, "R9 stays asleep", adc_pwr_n, 0);
        adc_val = 8'h6B;
        pulse_start();
        wait_valid();
        wait_cycles(2);
        check(last_wk == w + 1, "R8 wake gap", last_wk, w + 1);
        check(last_byte == 8'h6B, "R9 byte after wake", last_byte, 8'h6B);
        auto_sleep_en = 1'b0;
        ref_internal = 1'b0;
        wait_cycles(WEXT + 5);
        check(adc_pwr_n == 1'b1, "R9 powered when mode off", adc_pwr_n, 1);
    endtask

    task automatic t_recover();
        int v0 = n_valid;
        int c0;
        adc_val = 8'h77;
        pulse_start();
        wait_cycles(STRB + 5);
        sleep_req = 1'b1;
        wait_cycles(10);
        check(adc_pwr_n == 1'b0, "R10 forced sleep", adc_pwr_n, 0);
        check(adc_cnv == 1'b0 && adc_sclk == 1'b0, "R10 quiet pins", {adc_cnv, adc_sclk}, 0);
        c0 = n_cnv;
        sleep_req = 1'b0;
        wait_cycles(WEXT + CONV + 32 * HALF + 20);
        check(n_valid == v0, "R10 no valid on flush", n_valid, v0);
        check(n_cnv == c0, "R10 no strobe on flush", n_cnv, c0);
        check(rises == 8, "R10 eight flush clocks", rises, 8);
        check(last_rg == WEXT + CONV + HALF, "R10 flush timing", last_rg, WEXT + CONV + HALF);
        t_single(8'h81);
    endtask

    initial begin
        t_reset();
        t_single(8'hA5);
        t_single(8'h00);
        t_single(8'hFF);
        t_single(8'h5A);
        t_held();
        t_auto(1'b0);
        t_auto(1'b1);
        t_recover();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule